// File: doc/BRIEF.md
# Two-Phase Load/Store Processor Core

This block is a compact 32-bit load/store processor. Each instruction takes exactly two clock cycles. In the first cycle the core copies the memory word at the program counter into an instruction register. In the second cycle it decodes that register and carries out the operation, then moves the program counter on. The core holds thirty-two 32-bit general registers and a small memory that serves both instructions and data. On reset the memory is loaded with a fixed self-test program and its data.

The core accepts eight operations: load word, store word, add, subtract, signed set-on-less-than, branch when equal, branch when not equal, and an absolute jump. Any other encoding does nothing except advance the program counter. Addresses count bytes, and the core accesses only whole aligned words. Outside logic sees the state through a combinational debug port. One selector reads a general register, a second selector reads a memory word, and the current program counter is always visible.

Top module: `fx_core`

## Requirements
- R1: While reset (rst_n low, sampled on the rising clock edge) is asserted, the program counter is 0 and the core is in its fetch cycle. Every general register reads 0, and memory holds the boot image, so word 40 reads 21 and word 44 reads 0.
- R2: After reset is released, fetch and execute cycles alternate. The program counter stays unchanged across a fetch cycle and changes only at the end of an execute cycle. After one edge it still reads 0, and after two edges it reads 4.
- R3: The top 6 bits [31:26] of an instruction are the opcode. Bits [25:21] select the first source register, bits [20:16] the second source or target register, and bits [15:0] hold the immediate. Opcode 35 loads the memory word at (first source + sign-extended immediate) into the target register.
- R4: Opcode 43 stores the second source register into the memory word at (first source + sign-extended immediate).
- R5: Opcode 0 is register format: destination in bits [15:11], function in bits [5:0]. Function 32 writes first source + second source, and function 34 writes first source − second source. Both then advance the program counter by 4.
- R6: Opcode 0 with function 42 writes 1 when the first source is less than the second as signed numbers, and 0 otherwise.
- R7: Opcode 4 (equal) and opcode 5 (not equal) compare the two sources. When the condition holds, the next program counter is PC+4 plus the sign-extended immediate shifted left by 2. When it fails, the next program counter is PC+4.
- R8: Opcode 2 always sets the next program counter to the upper 4 bits of PC+4 joined with bits [25:0] shifted left by 2.
- R9: Register 0 always reads 0, and writes to it are discarded.
- R10: A negative immediate is sign-extended, so it forms addresses below the base register for both loads and stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_reg_sel | input | 5 | General register selected for debug read |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_mem_word | input | AW | Memory word index selected for debug read |
| dbg_mem_data | output | 32 | Value of the selected memory word |
| dbg_pc | output | 32 | Current program counter (byte address) |

## Verification
The embedded properties assume that every load and store address the program forms is word-aligned. They also assume every address falls inside the memory, because the word index wraps silently and the low address bits are ignored. They further assume that reset is held through at least one rising edge, so that the boot image and a cleared register file are in place. The stimulus stays within these limits because it never drives instructions directly. It runs only the boot program, whose bases and offsets are multiples of four and which halts in a jump-to-self well before any address runs off the end of memory. The debug selectors are changed only between clock edges and read combinationally, so they never disturb execution.

// File: rtl/fx_core.sv
module fx_core #(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    dbg_reg_sel,
  output logic [31:0]   dbg_reg_data,
  input  logic [AW-1:0] dbg_mem_word,
  output logic [31:0]   dbg_mem_data,
  output logic [31:0]   dbg_pc
);

  localparam logic [5:0] OP_R = 6'd0, OP_J = 6'd2, OP_BEQ = 6'd4, OP_BNE = 6'd5,
                         OP_LW = 6'd35, OP_SW = 6'd43;
  localparam logic [5:0] FN_ADD = 6'd32, FN_SUB = 6'd34, FN_SLT = 6'd42;

  function automatic logic [31:0] enc_r(input logic [4:0] s, t, d, input logic [5:0] f);
    return {OP_R, s, t, d, 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] o, input logic [4:0] s, t,
                                        input logic [15:0] k);
    return {o, s, t, k};
  endfunction

  function automatic logic [31:0] boot_word(input int i);
    case (i)
      0:  return enc_i(OP_LW, 5'd0, 5'd1, 16'd160);
      1:  return enc_i(OP_LW, 5'd0, 5'd2, 16'd164);
      2:  return enc_r(5'd1, 5'd2, 5'd3, FN_ADD);
      3:  return enc_i(OP_SW, 5'd0, 5'd3, 16'd176);
      4:  return enc_r(5'd1, 5'd2, 5'd4, FN_SUB);
      5:  return enc_i(OP_LW, 5'd0, 5'd5, 16'd168);
      6:  return enc_r(5'd5, 5'd1, 5'd6, FN_SLT);
      7:  return enc_r(5'd1, 5'd5, 5'd7, FN_SLT);
      8:  return enc_r(5'd1, 5'd2, 5'd0, FN_ADD);
      9:  return enc_i(OP_BEQ, 5'd1, 5'd2, 16'd1);
      10: return enc_i(OP_BNE, 5'd1, 5'd2, 16'd1);
      11: return enc_r(5'd1, 5'd1, 5'd8, FN_ADD);
      12: return enc_i(OP_BEQ, 5'd1, 5'd1, 16'd1);
      13: return enc_r(5'd2, 5'd2, 5'd8, FN_ADD);
      14: return enc_i(OP_BNE, 5'd2, 5'd2, 16'd1);
      15: return enc_r(5'd3, 5'd0, 5'd10, FN_ADD);
      16: return enc_i(OP_LW, 5'd0, 5'd12, 16'd172);
      17: return enc_i(OP_LW, 5'd12, 5'd11, 16'hFFFC);
      18: return enc_i(OP_SW, 5'd12, 5'd5, 16'd4);
      19: return {OP_J, 26'd21};
      20: return enc_r(5'd1, 5'd1, 5'd13, FN_ADD);
      21: return enc_r(5'd1, 5'd0, 5'd14, FN_ADD);
      22: return enc_r(5'd4, 5'd0, 5'd15, FN_SLT);
      23: return {OP_J, 26'd23};
      40: return 32'd21;
      41: return 32'd23;
      42: return 32'hFFFF_FFFB;
      43: return 32'd184;
      45: return 32'h1234_5678;
      default: return 32'd0;
    endcase
  endfunction

  logic        exec;
  logic [31:0] pc, ir;
  logic [31:0] rf  [32];
  logic [31:0] mem [MEM_WORDS];

  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd;
  logic [31:0] sx, a, b, ea, pc4, br_tgt, j_tgt, alu, next_pc;
  logic [AW-1:0] ea_w, pc_w;
  logic        wr_en, st_en, take;
  logic [4:0]  wr_idx;
  logic [31:0] wr_val;

  assign op  = ir[31:26];
  assign rs  = ir[25:21];
  assign rt  = ir[20:16];
  assign rd  = ir[15:11];
  assign fn  = ir[5:0];
  assign sx  = {{16{ir[15]}}, ir[15:0]};
  assign a   = rf[rs];
  assign b   = rf[rt];
  assign ea  = a + sx;
  assign ea_w = ea[AW+1:2];
  assign pc_w = pc[AW+1:2];
  assign pc4 = pc + 32'd4;
  assign br_tgt = pc4 + {sx[29:0], 2'b00};
  assign j_tgt  = {pc4[31:28], ir[25:0], 2'b00};

  always_comb begin
    case (fn)
      FN_ADD:  alu = a + b;
      FN_SUB:  alu = a - b;
      FN_SLT:  alu = {31'd0, $signed(a) < $signed(b)};
      default: alu = 32'd0;
    endcase
  end

  assign take = (op == OP_BEQ && a == b) || (op == OP_BNE && a != b);

  always_comb begin
    if (op == OP_J)   next_pc = j_tgt;
    else if (take)    next_pc = br_tgt;
    else              next_pc = pc4;
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = rd;
    wr_val = alu;
    if (op == OP_R && (fn == FN_ADD || fn == FN_SUB || fn == FN_SLT)) wr_en = 1'b1;
    if (op == OP_LW) begin
      wr_en  = 1'b1;
      wr_idx = rt;
      wr_val = mem[ea_w];
    end
  end

  assign st_en = (op == OP_SW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec <= 1'b0;
      pc   <= 32'd0;
      ir   <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= boot_word(i);
    end else if (!exec) begin
      ir   <= mem[pc_w];
      exec <= 1'b1;
    end else begin
      pc   <= next_pc;
      exec <= 1'b0;
      if (wr_en && wr_idx != 5'd0) rf[wr_idx] <= wr_val;
      if (st_en) mem[ea_w] <= b;
    end
  end

  assign dbg_reg_data = rf[dbg_reg_sel];
  assign dbg_mem_data = mem[dbg_mem_word];
  assign dbg_pc       = pc;

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !exec);
  // R2
  fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> exec && $stable(pc));
  // R5
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_R |=> pc == $past(pc) + 32'd4);
  // R7
  bne_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_BNE && a == b |=> pc == $past(pc) + 32'd4);
  // R3
  load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_LW && rt != 5'd0 |=> rf[$past(rt)] == $past(mem[ea_w]));
  // R9
  r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == 32'd0);
  // R8
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

endmodule

// File: tb/sim_fx_core.sv
module sim_fx_core;
  localparam int MW = 64;
  localparam int AW = $clog2(MW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    dbg_reg_sel = '0;
  logic [31:0]   dbg_reg_data;
  logic [AW-1:0] dbg_mem_word = '0;
  logic [31:0]   dbg_mem_data;
  logic [31:0]   dbg_pc;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fx_core #(.MEM_WORDS(MW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_word(dbg_mem_word), .dbg_mem_data(dbg_mem_data),
    .dbg_pc(dbg_pc));

  // {kind(0 reg,1 mem,2 pc), index, expected, requirement}
  localparam logic [43:0] VEC [18] = '{
    {2'd0, 6'd1,  32'd21,         4'd3},  // R3 load
    {2'd0, 6'd2,  32'd23,         4'd3},  // R3 load
    {2'd0, 6'd3,  32'd44,         4'd5},  // R5 add
    {2'd1, 6'd44, 32'd44,         4'd4},  // R4 store
    {2'd0, 6'd4,  32'hFFFF_FFFE,  4'd5},  // R5 subtract
    {2'd0, 6'd5,  32'hFFFF_FFFB,  4'd3},  // R3 negative data
    {2'd0, 6'd6,  32'd1,          4'd6},  // R6 signed less
    {2'd0, 6'd7,  32'd0,          4'd6},  // R6 not less
    {2'd0, 6'd0,  32'd0,          4'd9},  // R9 write to r0 dropped
    {2'd0, 6'd8,  32'd0,          4'd7},  // R7 taken branches skip
    {2'd0, 6'd10, 32'd44,         4'd7},  // R7 fall-through executed
    {2'd0, 6'd12, 32'd184,        4'd3},  // R3 base load
    {2'd0, 6'd11, 32'h1234_5678,  4'd10}, // R10 negative offset load
    {2'd1, 6'd47, 32'hFFFF_FFFB,  4'd10}, // R10 store via base
    {2'd0, 6'd13, 32'd0,          4'd8},  // R8 jump skips
    {2'd0, 6'd14, 32'd21,         4'd8},  // R8 jump target runs
    {2'd0, 6'd15, 32'd1,          4'd6},  // R6 -2 < 0
    {2'd2, 6'd0,  32'd92,         4'd8}   // R8 halted at jump-to-self
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_reg(input int i, output logic [31:0] v);
    dbg_reg_sel = i[4:0];
    #1 v = dbg_reg_data;
  endtask

  task automatic rd_mem(input int i, output logic [31:0] v);
    dbg_mem_word = i[AW-1:0];
    #1 v = dbg_mem_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", dbg_pc, 32'd0);
    rd_reg(1, v);  chk("R1 reg", v, 32'd0);
    rd_mem(40, v); chk("R1 boot data", v, 32'd21);
    rd_mem(44, v); chk("R1 boot zero", v, 32'd0);

    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 after fetch", dbg_pc, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 after execute", dbg_pc, 32'd4);
    @(posedge clk); @(negedge clk);
    chk("R2 second fetch", dbg_pc, 32'd4);

    repeat (120) @(negedge clk);
    for (int k = 0; k < 18; k++) begin
      logic [43:0] e;
      e = VEC[k];
      if (e[43:42] == 2'd0)      rd_reg(int'(e[41:36]), v);
      else if (e[43:42] == 2'd1) rd_mem(int'(e[41:36]), v);
      else                       v = dbg_pc;
      chk($sformatf("R%0d vector %0d", e[3:0], k), v, e[35:4]);
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 re-reset pc", dbg_pc, 32'd0);
    rd_reg(14, v); chk("R1 re-reset reg", v, 32'd0);
    rd_mem(47, v); chk("R1 re-reset image", v, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule